// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port of sixteen pins behind a small register bus. Each pin has its own direction bit, so it either drives its output latch onto the pad or is observed as an input. The latch is normally changed through two write-only strobe registers. A one written to a bit of the first raises that pin's latch, and a one written to a bit of the second lowers it. Bits written as zero leave the latch alone, so software never needs a read-modify-write.

Every pin input first passes through a two-flop synchronizer. The synchronized value feeds both the data-in register and a per-pin event detector. The detector can trigger on a high level, a low level, a rising edge, a falling edge, or either edge. A pin is armed only when its mask bit is clear and its enable bit is set. An armed event latches a pending bit. Software reads the pending bits through a status register and clears them by writing ones. The single `irq` output is the OR of the status bits.

The bus is synchronous. A request is a one-cycle `busSel` pulse with `busWr` selecting write or read. Write data takes effect at that edge. Read data appears on `busRdata` from the following edge and holds until the next read.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the mask register (0x28) reads 0xFFFF, and enable (0x2C), direction (0x00), data-out (0x20) and status (0x30) read 0. `pinOe`, `pinOut` and `irq` are 0.
- R2: Direction (0x00), level-select (0x04), level-polarity (0x08), rising enable (0x0C), falling enable (0x10), mask (0x28) and enable (0x2C) read back the last value written. Direction bit i = 1 drives `pinOe[i]` high (output), and 0 makes the pin an input.
- R3: A 1 in bit i written to 0x18 sets latch bit i, and a 1 written to 0x1C clears it. Zero bits leave the latch unchanged. A write to 0x20 loads the whole latch. `pinOut` and a read of 0x20 show the latch from the edge after the write.
- R4: A read of 0x14 returns `pinIn` after the two-flop synchronizer. A pin change is visible in reads issued three or more cycles later.
- R5: With level-select bit 1, polarity 1 triggers on a high level and polarity 0 triggers on a low level. The pending bit is set again every cycle the level is active, so a clear does not remove it while the level persists.
- R6: With level-select bit 0, the rising-enable and falling-enable bits act independently. Setting both triggers on either edge. An edge is a change between two consecutive synchronized samples, and it sets pending only once.
- R7: An event sets pending only when the pin's mask bit is 0 and its enable bit is 1. Status (0x30) shows pending bits that are both unmasked and enabled.
- R8: Writing ones to 0x34 clears the matching pending bits. If a clear and a new event for the same pin fall on the same edge, the bit stays set.
- R9: `irq` is 1 exactly when status is nonzero.
- R10: Offsets 0x18, 0x1C and 0x34 read as 0. Any other unlisted offset reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus request valid for this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte offset of the register |
| busWdata | input | 16 | Write data, one bit per pin |
| busRdata | output | 16 | Read data, valid from the edge after a read request |
| pinIn | input | 16 | Pad input levels, asynchronous |
| pinOut | output | 16 | Output latch value |
| pinOe | output | 16 | Output enable per pin (direction) |
| irq | output | 1 | Combined interrupt request |

## Verification
Most internal faults in this block surface at the ports within a few cycles:
- A wrong latch or direction bit appears on `pinOut` or `pinOe` at the edge after the bus write.
- A wrong synchronizer depth or a wrong edge sample shifts or duplicates events. This shows in status reads taken three to four cycles after a pin change.
- Wrong pending logic shows as a status bit that survives a clear on an edge-triggered pin, a level-triggered bit that vanishes after a clear, or a bit that latches while the pin is masked or disabled. In each case `irq` agrees with status in the same cycle.

The hardest timing is a clear that lands on the same edge as a new event. It is exercised by placing the clear write on exactly that edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_DIR  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_LSEL = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_LPOL = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_RISE = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_FALL = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_DIN  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_SET  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_DOUT = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_EN   = 6'h2C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_ICLR = 6'h34;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DIR, SEL_LSEL, SEL_LPOL, SEL_RISE, SEL_FALL, SEL_DIN,
    SEL_SET, SEL_CLR, SEL_DOUT, SEL_MASK, SEL_EN, SEL_STAT, SEL_ICLR
  } regSel_e;

  typedef struct packed {
    logic    wrStb;
    logic    rdStb;
    regSel_e sel;
  } busStb_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busStb_t           stb
);

  regSel_e sel;

  always_comb begin
    case (busAddr)
      OFS_DIR:  sel = SEL_DIR;
      OFS_LSEL: sel = SEL_LSEL;
      OFS_LPOL: sel = SEL_LPOL;
      OFS_RISE: sel = SEL_RISE;
      OFS_FALL: sel = SEL_FALL;
      OFS_DIN:  sel = SEL_DIN;
      OFS_SET:  sel = SEL_SET;
      OFS_CLR:  sel = SEL_CLR;
      OFS_DOUT: sel = SEL_DOUT;
      OFS_MASK: sel = SEL_MASK;
      OFS_EN:   sel = SEL_EN;
      OFS_STAT: sel = SEL_STAT;
      OFS_ICLR: sel = SEL_ICLR;
      default:  sel = SEL_NONE;
    endcase
  end

  always_comb begin
    stb.sel   = sel;
    stb.wrStb = busSel && busWr && (sel != SEL_NONE);
    stb.rdStb = busSel && !busWr;
  end

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStb_t          stb,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] pinIn,
  output logic [NPINS-1:0] rdata,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe
);

  localparam logic [NPINS-1:0] ALL_ONES = '1;

  logic [NPINS-1:0] dirReg, lvlSel, lvlPol, riseEn, fallEn;
  logic [NPINS-1:0] outLatch, maskReg, enReg, pending;
  logic [NPINS-1:0] syncChain [SYNC_STAGES];
  logic [NPINS-1:0] pinNow, pinPrev;
  logic [NPINS-1:0] armed, evt, statusVec, rdMux;

  function automatic logic hit(input busStb_t s, input regSel_e r);
    return s.wrStb && (s.sel == r);
  endfunction

  // input synchronizer and previous-sample register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= '0;
      pinPrev <= '0;
    end else begin
      syncChain[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
      pinPrev <= syncChain[SYNC_STAGES-1];
    end
  end

  assign pinNow = syncChain[SYNC_STAGES-1];

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      lvlSel  <= '0;
      lvlPol  <= '0;
      riseEn  <= '0;
      fallEn  <= '0;
      maskReg <= ALL_ONES;
      enReg   <= '0;
    end else begin
      if (hit(stb, SEL_DIR))  dirReg  <= wdata;
      if (hit(stb, SEL_LSEL)) lvlSel  <= wdata;
      if (hit(stb, SEL_LPOL)) lvlPol  <= wdata;
      if (hit(stb, SEL_RISE)) riseEn  <= wdata;
      if (hit(stb, SEL_FALL)) fallEn  <= wdata;
      if (hit(stb, SEL_MASK)) maskReg <= wdata;
      if (hit(stb, SEL_EN))   enReg   <= wdata;
    end
  end

  // output latch with set / clear / load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLatch <= '0;
    end else if (hit(stb, SEL_SET)) begin
      outLatch <= outLatch | wdata;
    end else if (hit(stb, SEL_CLR)) begin
      outLatch <= outLatch & ~wdata;
    end else if (hit(stb, SEL_DOUT)) begin
      outLatch <= wdata;
    end
  end

  // per-pin event detection
  assign armed = ~maskReg & enReg;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic lvlHit, edgeHit;
    assign lvlHit  = (pinNow[i] == lvlPol[i]);
    assign edgeHit = (riseEn[i] &  pinNow[i] & ~pinPrev[i]) |
                     (fallEn[i] & ~pinNow[i] &  pinPrev[i]);
    assign evt[i]  = armed[i] & (lvlSel[i] ? lvlHit : edgeHit);
  end

  // pending: a new event wins over a clear on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
    end else if (hit(stb, SEL_ICLR)) begin
      pending <= (pending & ~wdata) | evt;
    end else begin
      pending <= pending | evt;
    end
  end

  assign statusVec = pending & armed;

  // read path
  always_comb begin
    case (stb.sel)
      SEL_DIR:  rdMux = dirReg;
      SEL_LSEL: rdMux = lvlSel;
      SEL_LPOL: rdMux = lvlPol;
      SEL_RISE: rdMux = riseEn;
      SEL_FALL: rdMux = fallEn;
      SEL_DIN:  rdMux = pinNow;
      SEL_DOUT: rdMux = outLatch;
      SEL_MASK: rdMux = maskReg;
      SEL_EN:   rdMux = enReg;
      SEL_STAT: rdMux = statusVec;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdata <= '0;
    else if (stb.rdStb) rdata <= rdMux;
  end

  assign pinOut = outLatch;
  assign pinOe  = dirReg;

  // combined request, exported for the top
  logic irqOut;
  assign irqOut = |statusVec;

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NPINS-1:0]  busWdata,
  output logic [NPINS-1:0]  busRdata,
  input  logic [NPINS-1:0]  pinIn,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinOe,
  output logic              irq
);

  busStb_t stb;

  gpio_irq_ctrl u_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .stb     (stb)
  );

  gpio_irq_dp #(
    .NPINS       (NPINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wdata  (busWdata),
    .pinIn  (pinIn),
    .rdata  (busRdata),
    .pinOut (pinOut),
    .pinOe  (pinOe)
  );

  assign irq = u_dp.irqOut;

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [NPINS-1:0]  busWdata,
  input logic [NPINS-1:0]  busRdata,
  input logic [NPINS-1:0]  pinOut,
  input logic [NPINS-1:0]  pinOe,
  input logic              irq,
  input logic [NPINS-1:0]  maskVal
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (pinOe == '0 && pinOut == '0 && !irq));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == OFS_DIR) |=> (pinOe == $past(busWdata)));

  // R3
  set_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == OFS_SET) |=>
      (pinOut == ($past(pinOut) | $past(busWdata))));

  // R3
  clr_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == OFS_CLR) |=>
      (pinOut == ($past(pinOut) & ~$past(busWdata))));

  // R10
  strobe_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && (busAddr == OFS_SET || busAddr == OFS_CLR ||
                          busAddr == OFS_ICLR)) |=> (busRdata == '0));

  // R9
  status_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == OFS_STAT && !irq) |=> (busRdata == '0));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&maskVal) |-> !irq);

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .pinOut   (pinOut),
  .pinOe    (pinOe),
  .irq      (irq),
  .maskVal  (u_dp.maskReg)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  import gpio_irq_pkg::*;

  localparam int NP = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN;
  logic              busSel, busWr;
  logic [ADDR_W-1:0] busAddr;
  logic [NP-1:0]     busWdata, busRdata, pinIn, pinOut, pinOe;
  logic              irq;

  int  nChk = 0;
  int  nBad = 0;
  bit  done = 0;

  gpio_irq_port uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irq(irq)
  );

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [NP-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPin(input int b, input logic v);
    @(negedge clk);
    pinIn[b] = v;
    waitc(4);
  endtask

  function automatic logic [NP-1:0] bitOf(input int b);
    return NP'(1) << b;
  endfunction

  task automatic expectStat(input string req, input logic [NP-1:0] exp);
    logic [NP-1:0] v;
    rd(OFS_STAT, v);
    chk(req, v, exp);
    chk("R9", {15'd0, irq}, {15'd0, exp != '0});
  endtask

  logic [NP-1:0] shDir, shOut, v, d;

  initial begin
    rstN = 1'b0; busSel = 1'b0; busWr = 1'b0; busAddr = '0; busWdata = '0; pinIn = '0;
    shDir = '0; shOut = '0;
    void'($urandom(32'd20240611));
    waitc(3);
    rstN = 1'b1;
    waitc(2);

    // R1 reset state
    rd(OFS_MASK, v); chk("R1 mask", v, 16'hFFFF);
    rd(OFS_EN, v);   chk("R1 enable", v, 16'h0000);
    rd(OFS_DIR, v);  chk("R1 dir", v, 16'h0000);
    rd(OFS_DOUT, v); chk("R1 dout", v, 16'h0000);
    rd(OFS_STAT, v); chk("R1 status", v, 16'h0000);
    chk("R1 pinOe", pinOe, '0);
    chk("R1 pinOut", pinOut, '0);
    chk("R1 irq", {15'd0, irq}, 16'h0);

    // R2 / R3 random direction and latch traffic
    for (int k = 0; k < 60; k++) begin
      int op;
      op = int'($urandom % 4);
      d  = NP'($urandom);
      case (op)
        0: begin wr(OFS_DIR, d); shDir = d; end
        1: begin wr(OFS_SET, d); shOut = shOut | d; end
        2: begin wr(OFS_CLR, d); shOut = shOut & ~d; end
        default: begin wr(OFS_DOUT, d); shOut = d; end
      endcase
      chk("R2 pinOe", pinOe, shDir);
      chk("R3 pinOut", pinOut, shOut);
      if (op == 0) begin rd(OFS_DIR, v); chk("R2 dir readback", v, shDir); end
      else begin rd(OFS_DOUT, v); chk("R3 dout readback", v, shOut); end
    end
    // R3 directed: zero bits leave latch alone
    wr(OFS_DOUT, 16'hA5A5); wr(OFS_SET, 16'h0000); chk("R3 set zero", pinOut, 16'hA5A5);
    wr(OFS_CLR, 16'h0000);  chk("R3 clr zero", pinOut, 16'hA5A5);
    wr(OFS_SET, 16'h0102);  chk("R3 set", pinOut, 16'hA5A7);
    wr(OFS_CLR, 16'h8001);  chk("R3 clr", pinOut, 16'h25A6);
    shOut = 16'h25A6;

    // R2 configuration readback
    for (int k = 0; k < 12; k++) begin
      logic [ADDR_W-1:0] a;
      case (k % 6)
        0: a = OFS_LSEL; 1: a = OFS_LPOL; 2: a = OFS_RISE;
        3: a = OFS_FALL; 4: a = OFS_MASK; default: a = OFS_EN;
      endcase
      d = NP'($urandom);
      wr(a, d); rd(a, v); chk("R2 config readback", v, d);
    end
    wr(OFS_MASK, 16'hFFFF); wr(OFS_EN, 16'h0000);
    wr(OFS_LSEL, 16'h0000); wr(OFS_LPOL, 16'h0000);
    wr(OFS_RISE, 16'h0000); wr(OFS_FALL, 16'h0000);
    wr(OFS_ICLR, 16'hFFFF);

    // R4 data-in through synchronizer
    for (int k = 0; k < 10; k++) begin
      d = NP'($urandom);
      @(negedge clk); pinIn = d;
      waitc(3);
      rd(OFS_DIN, v); chk("R4 data-in", v, d);
    end
    @(negedge clk); pinIn = '0;
    waitc(4);
    wr(OFS_ICLR, 16'hFFFF);
    wr(OFS_EN, 16'hFFFF);

    // R5 level high on pin 0, retriggers after clear
    wr(OFS_LSEL, 16'h0003); wr(OFS_LPOL, 16'h0001);
    wr(OFS_MASK, ~bitOf(0));
    expectStat("R5 high idle", 16'h0000);
    setPin(0, 1'b1);
    expectStat("R5 high active", 16'h0001);
    wr(OFS_ICLR, 16'h0001);
    expectStat("R5 retrigger", 16'h0001);
    setPin(0, 1'b0);
    wr(OFS_ICLR, 16'h0001);
    expectStat("R8 cleared", 16'h0000);
    // R5 level low on pin 1 (pin already low)
    wr(OFS_MASK, ~bitOf(1));
    waitc(2);
    expectStat("R5 low active", 16'h0002);
    setPin(1, 1'b1);
    wr(OFS_ICLR, 16'h0002);
    expectStat("R5 low released", 16'h0000);
    wr(OFS_LSEL, 16'h0000);

    // R6 rising only on pin 2
    wr(OFS_RISE, bitOf(2)); wr(OFS_MASK, ~bitOf(2));
    setPin(2, 1'b1);
    expectStat("R6 rise", bitOf(2));
    wr(OFS_ICLR, bitOf(2));
    expectStat("R6 edge once", 16'h0000);
    setPin(2, 1'b0);
    expectStat("R6 no fall", 16'h0000);
    // R6 falling only on pin 3
    setPin(3, 1'b1);
    wr(OFS_FALL, bitOf(3)); wr(OFS_RISE, 16'h0000); wr(OFS_MASK, ~bitOf(3));
    expectStat("R6 fall idle", 16'h0000);
    setPin(3, 1'b0);
    expectStat("R6 fall", bitOf(3));
    wr(OFS_ICLR, bitOf(3));
    setPin(3, 1'b1);
    expectStat("R6 no rise", 16'h0000);
    // R6 both edges on pin 4
    wr(OFS_RISE, bitOf(4)); wr(OFS_FALL, bitOf(4)); wr(OFS_MASK, ~bitOf(4));
    setPin(4, 1'b1);
    expectStat("R6 both rise", bitOf(4));
    wr(OFS_ICLR, bitOf(4));
    setPin(4, 1'b0);
    expectStat("R6 both fall", bitOf(4));
    wr(OFS_ICLR, bitOf(4));
    wr(OFS_FALL, 16'h0000);

    // R7 masked, then disabled, then armed on pin 5
    wr(OFS_RISE, bitOf(5)); wr(OFS_MASK, 16'hFFFF);
    setPin(5, 1'b1);
    expectStat("R7 masked", 16'h0000);
    wr(OFS_EN, ~bitOf(5)); wr(OFS_MASK, ~bitOf(5));
    setPin(5, 1'b0); setPin(5, 1'b1);
    expectStat("R7 disabled", 16'h0000);
    wr(OFS_EN, 16'hFFFF);
    expectStat("R7 no stale", 16'h0000);
    setPin(5, 1'b0); setPin(5, 1'b1);
    expectStat("R7 armed", bitOf(5));
    wr(OFS_ICLR, bitOf(5));

    // R8 clear and new event on the same edge, pin 7
    wr(OFS_RISE, bitOf(7)); wr(OFS_MASK, ~bitOf(7));
    setPin(7, 1'b1);
    expectStat("R8 first", bitOf(7));
    setPin(7, 1'b0);
    expectStat("R8 held", bitOf(7));
    @(negedge clk); pinIn[7] = 1'b1;
    @(negedge clk);
    wr(OFS_ICLR, bitOf(7));
    expectStat("R8 event wins", bitOf(7));
    wr(OFS_ICLR, bitOf(7));
    expectStat("R8 plain clear", 16'h0000);

    // R10 strobe registers and unused offsets
    rd(OFS_SET, v);  chk("R10 set reads 0", v, 16'h0000);
    rd(OFS_CLR, v);  chk("R10 clr reads 0", v, 16'h0000);
    rd(OFS_ICLR, v); chk("R10 iclr reads 0", v, 16'h0000);
    wr(6'h24, 16'hFFFF); wr(6'h3C, 16'hFFFF); wr(6'h01, 16'hFFFF);
    rd(6'h24, v); chk("R10 unused 0x24", v, 16'h0000);
    rd(6'h3C, v); chk("R10 unused 0x3C", v, 16'h0000);
    rd(OFS_DIR, v); chk("R10 dir untouched", v, shDir);
    chk("R10 latch untouched", pinOut, shOut);
    rd(OFS_MASK, v); chk("R10 mask untouched", v, ~bitOf(7));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule